// File: doc/BRIEF.md
# HDLC Channel Rate Negotiator

This block selects the operating rate of the slow control-and-management HDLC channel carried on a serial radio-interface link. A management write port loads the local preferred rate. The far end advertises a mask of the rates it can run. When the link is up, the block offers every rate that the local end supports up to the preferred one. It then picks the highest rate found in both the local offer and the remote mask, and reports it as a current-rate code. The block also raises a one-cycle done pulse when it enters the operational state.

While the link is up, a management write that changes the preferred rate throws away the agreed rate and starts the negotiation again. One reserved preferred code marks the rate as settled by a higher layer. With that code the block skips the comparison, reports the reserved code, and latches a 10-bit byte-valid mask supplied by that higher layer. While this code is in force, rate adaptation is held off.

Top module: `hdlc_rate_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns after that edge to IDLE (state code 0), with `cur_code` 0, `neg_done` 0, `byte_mask` 0 and the stored preferred code equal to the parameter `DEFAULT_PREF` (5).
- R2: State codes are IDLE=0, ADVERTISE=1, COMPARE=2 and OPERATIONAL=3. From IDLE with `link_up` high the block moves to ADVERTISE at the next edge. `link_up` low at any edge forces IDLE with `cur_code` 0 and `byte_mask` 0.
- R3: Rate codes are 1=240, 2=480, 3=960, 4=1920 and 5=2400 kb/s. Bit i-1 of `remote_caps` and of `LOCAL_CAPS` marks code i. In ADVERTISE, with a predefined preferred code and `remote_valid` high, the block latches `remote_caps` and moves to COMPARE. The local offer contains each code i with its `LOCAL_CAPS` bit set and i no greater than the preferred code.
- R4: In COMPARE, if the offer and the latched remote mask share a code, the next edge sets `cur_code` to the highest shared code and enters OPERATIONAL. `neg_done` is high for exactly the one cycle after that edge.
- R5: In COMPARE with no shared code, the next edge returns to ADVERTISE with `cur_code` 0 and no done pulse. The block then waits in ADVERTISE until `remote_valid` is high.
- R6: A write (`pref_wr` high) of code 1 to 5 or 7 updates the stored preferred code. Writes of 0 or 6 are ignored and cause no restart.
- R7: An accepted write whose value differs from the stored code, made in any state other than IDLE, moves the block to ADVERTISE with `cur_code` 0 and `byte_mask` 0 at that edge. Rewriting the stored value has no effect.
- R8: In ADVERTISE with stored preferred code 7, the next edge enters OPERATIONAL with `cur_code` 7 and a done pulse, and latches `user_mask` into `byte_mask`. `remote_caps` and later changes of `user_mask` are ignored.
- R9: `adapt_en` equals `adapt_req` while in OPERATIONAL with `cur_code` 1 to 5. It is 0 in every other case, and always 0 while `cur_code` is 7.
- R10: `cur_code` is 0 in every state other than OPERATIONAL, and never takes the value 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Link operational; low returns the block to IDLE |
| pref_wr | input | 1 | Management write strobe for the preferred rate |
| pref_wdata | input | 3 | Preferred rate code being written |
| remote_valid | input | 1 | Far-end capability mask is valid |
| remote_caps | input | 5 | Far-end supported rate codes, bit i-1 for code i |
| user_mask | input | 10 | Higher-layer byte-valid mask for the user-defined rate |
| adapt_req | input | 1 | Request for rate adaptation |
| cur_code | output | 3 | Current negotiated rate code |
| neg_state | output | 2 | Negotiation state code |
| neg_done | output | 1 | One-cycle pulse on entering OPERATIONAL |
| byte_mask | output | 10 | Latched higher-layer byte-valid mask |
| adapt_en | output | 1 | Rate adaptation permitted |

## Verification
Every result is registered once. `neg_state`, `cur_code`, `neg_done` and `byte_mask` reflect the inputs sampled at an edge just after that edge. A full negotiation from IDLE therefore takes three edges: to ADVERTISE, to COMPARE, then to OPERATIONAL. The user-defined path skips COMPARE, and a restart reaches ADVERTISE at the same edge as the write. `adapt_en` is combinational from state and `adapt_req`. The bench changes inputs one nanosecond after a rising edge. A behavioural reference advances on each rising edge and is compared with the outputs on the falling edge. Directed checks are taken one nanosecond after the edge whose outcome they test.

// File: rtl/hdlc_rate_pkg.sv
// Package: shared encodings for the HDLC rate negotiator.
// Assumes rate codes 1..NUM_RATES are ordered from slowest to fastest.
package hdlc_rate_pkg;

    localparam int CODE_W      = 3;
    localparam int NUM_RATES   = 5;
    localparam logic [CODE_W-1:0] CODE_NONE = 3'd0;
    localparam logic [CODE_W-1:0] CODE_RSVD = 3'd6;
    localparam logic [CODE_W-1:0] CODE_USER = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ADVERTISE = 2'd1,
        ST_COMPARE   = 2'd2,
        ST_OPER      = 2'd3
    } neg_state_t;

    // True for a code that names one of the predefined rates.
    function automatic logic is_rate_code(input logic [CODE_W-1:0] c);
        return (c != CODE_NONE) && (int'(c) <= NUM_RATES);
    endfunction

    // True for a code the preferred-rate register accepts.
    function automatic logic is_pref_code(input logic [CODE_W-1:0] c);
        return is_rate_code(c) || (c == CODE_USER);
    endfunction

endpackage

// File: rtl/hdlc_pref_store.sv
// Module: holds the local preferred rate code written by management.
// Accepts only predefined codes or the user-defined code; other writes
// are dropped. Flags an accepted write that changes the stored value,
// combinationally, so the controller can restart in the same edge.
module hdlc_pref_store
    import hdlc_rate_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEFAULT_PREF = 3'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CODE_W-1:0] wdata,
    output logic [CODE_W-1:0] pref,
    output logic              changed
);

    logic accept;

    // Decide whether the incoming write is legal and whether it differs.
    always_comb begin
        accept  = wr && is_pref_code(wdata);
        changed = accept && (wdata != pref);
    end

    // Store the preferred code; reset loads the default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pref <= DEFAULT_PREF;
        end else if (accept) begin
            pref <= wdata;
        end
    end

endmodule

// File: rtl/hdlc_offer_pick.sv
// Module: builds the local offer from the supported-rate mask and the
// preferred code, intersects it with the far-end mask, and returns the
// highest shared code. Purely combinational.
// Assumes bit i of each mask stands for rate code i+1.
module hdlc_offer_pick
    import hdlc_rate_pkg::*;
#(
    parameter int               RATES      = NUM_RATES,
    parameter logic [RATES-1:0] LOCAL_CAPS = '1
) (
    input  logic [CODE_W-1:0] pref,
    input  logic [RATES-1:0]  remote,
    output logic [RATES-1:0]  offer,
    output logic              found,
    output logic [CODE_W-1:0] best
);

    logic [RATES-1:0] common;

    // One offer bit per rate: supported locally and not above the preferred rate.
    for (genvar g = 0; g < RATES; g++) begin : g_offer
        assign offer[g] = LOCAL_CAPS[g] && (int'(pref) >= g + 1) && is_rate_code(pref);
    end

    assign common = offer & remote;

    // Priority pick: the highest shared rate wins.
    always_comb begin
        found = 1'b0;
        best  = CODE_NONE;
        for (int i = 0; i < RATES; i++) begin
            if (common[i]) begin
                found = 1'b1;
                best  = CODE_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/hdlc_neg_ctrl.sv
// Module: negotiation state machine. Walks IDLE, ADVERTISE, COMPARE and
// OPERATIONAL, owns the current-rate code, the done pulse and the
// higher-layer byte mask. Assumes the pick result is valid whenever the
// latched remote mask and the stored preferred code are stable.
module hdlc_neg_ctrl
    import hdlc_rate_pkg::*;
#(
    parameter int RATES  = NUM_RATES,
    parameter int MASK_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              restart,
    input  logic [CODE_W-1:0] pref,
    input  logic              remote_valid,
    input  logic [RATES-1:0]  remote_caps,
    input  logic [MASK_W-1:0] user_mask,
    input  logic              pick_found,
    input  logic [CODE_W-1:0] pick_code,
    output logic [RATES-1:0]  remote_q,
    output neg_state_t        state,
    output logic [CODE_W-1:0] code,
    output logic              done,
    output logic [MASK_W-1:0] bmask
);

    neg_state_t        state_n;
    logic [CODE_W-1:0] code_n;
    logic              done_n;
    logic [MASK_W-1:0] bmask_n;
    logic [RATES-1:0]  remote_n;

    // Next-state and next-output decision for one edge.
    always_comb begin
        state_n  = state;
        code_n   = code;
        done_n   = 1'b0;
        bmask_n  = bmask;
        remote_n = remote_q;
        if (!link_up) begin
            state_n = ST_IDLE;
            code_n  = CODE_NONE;
            bmask_n = '0;
        end else if (restart && (state != ST_IDLE)) begin
            state_n = ST_ADVERTISE;
            code_n  = CODE_NONE;
            bmask_n = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_n = ST_ADVERTISE;
                end
                ST_ADVERTISE: begin
                    if (pref == CODE_USER) begin
                        state_n = ST_OPER;
                        code_n  = CODE_USER;
                        done_n  = 1'b1;
                        bmask_n = user_mask;
                    end else if (remote_valid) begin
                        remote_n = remote_caps;
                        state_n  = ST_COMPARE;
                    end
                end
                ST_COMPARE: begin
                    if (pick_found) begin
                        state_n = ST_OPER;
                        code_n  = pick_code;
                        done_n  = 1'b1;
                    end else begin
                        state_n = ST_ADVERTISE;
                        code_n  = CODE_NONE;
                    end
                end
                ST_OPER: begin
                    state_n = ST_OPER;
                end
                default: begin
                    state_n = ST_IDLE;
                    code_n  = CODE_NONE;
                end
            endcase
        end
    end

    // Register the state, outputs and latched far-end mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            code     <= CODE_NONE;
            done     <= 1'b0;
            bmask    <= '0;
            remote_q <= '0;
        end else begin
            state    <= state_n;
            code     <= code_n;
            done     <= done_n;
            bmask    <= bmask_n;
            remote_q <= remote_n;
        end
    end

endmodule

// File: rtl/hdlc_rate_arbiter.sv
// Module (top): HDLC channel rate negotiator. Ties together the
// preferred-rate store, the offer/pick logic and the negotiation state
// machine, and gates rate adaptation. Assumes a single clock domain and
// that remote_caps is meaningful whenever remote_valid is high.
module hdlc_rate_arbiter
    import hdlc_rate_pkg::*;
#(
    parameter logic [2:0] DEFAULT_PREF = 3'd5,
    parameter logic [4:0] LOCAL_CAPS   = 5'b11111,
    parameter int         MASK_W       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              pref_wr,
    input  logic [2:0]        pref_wdata,
    input  logic              remote_valid,
    input  logic [4:0]        remote_caps,
    input  logic [MASK_W-1:0] user_mask,
    input  logic              adapt_req,
    output logic [2:0]        cur_code,
    output logic [1:0]        neg_state,
    output logic              neg_done,
    output logic [MASK_W-1:0] byte_mask,
    output logic              adapt_en
);

    logic [CODE_W-1:0]    pref;
    logic                 pref_changed;
    logic [NUM_RATES-1:0] remote_q;
    logic [NUM_RATES-1:0] offer;
    logic                 pick_found;
    logic [CODE_W-1:0]    pick_code;
    neg_state_t           state;

    hdlc_pref_store #(
        .DEFAULT_PREF (DEFAULT_PREF)
    ) u_pref (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (pref_wr),
        .wdata   (pref_wdata),
        .pref    (pref),
        .changed (pref_changed)
    );

    hdlc_offer_pick #(
        .RATES      (NUM_RATES),
        .LOCAL_CAPS (LOCAL_CAPS)
    ) u_pick (
        .pref   (pref),
        .remote (remote_q),
        .offer  (offer),
        .found  (pick_found),
        .best   (pick_code)
    );

    hdlc_neg_ctrl #(
        .RATES  (NUM_RATES),
        .MASK_W (MASK_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_up      (link_up),
        .restart      (pref_changed),
        .pref         (pref),
        .remote_valid (remote_valid),
        .remote_caps  (remote_caps),
        .user_mask    (user_mask),
        .pick_found   (pick_found),
        .pick_code    (pick_code),
        .remote_q     (remote_q),
        .state        (state),
        .code         (cur_code),
        .done         (neg_done),
        .bmask        (byte_mask)
    );

    // Drive the state code and allow adaptation only on a predefined rate.
    always_comb begin
        neg_state = state;
        adapt_en  = adapt_req && (state == ST_OPER) && is_rate_code(cur_code);
    end

endmodule

// File: rtl/hdlc_rate_arbiter_chk.sv
// Checker: temporal properties of the rate negotiator, bound to the top.
module hdlc_rate_arbiter_chk #(
    parameter int MASK_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              link_up,
    input logic              pref_wr,
    input logic [2:0]        pref_wdata,
    input logic              adapt_req,
    input logic [2:0]        cur_code,
    input logic [1:0]        neg_state,
    input logic              neg_done,
    input logic [MASK_W-1:0] byte_mask,
    input logic              adapt_en
);

    AST_LINK_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (neg_state == 2'd0 && cur_code == 3'd0)); // R2

    AST_DONE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        neg_done |-> (neg_state == 2'd3 && $past(neg_state) != 2'd3)); // R4

    AST_COMPARE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        neg_state == 2'd2 |=> neg_state != 2'd2); // R4

    AST_CODE_ZERO_OUTSIDE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        neg_state != 2'd3 |-> cur_code == 3'd0); // R10

    AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_code != 3'd6); // R10

    AST_NO_ADAPT_USER: assert property (@(posedge clk) disable iff (!rst_n)
        cur_code == 3'd7 |-> !adapt_en); // R9

    AST_USER_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_state == 2'd3 && $past(neg_state) == 2'd3 && link_up && !pref_wr)
        |=> $stable(byte_mask)); // R8

endmodule

bind hdlc_rate_arbiter hdlc_rate_arbiter_chk #(.MASK_W(MASK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_up    (link_up),
    .pref_wr    (pref_wr),
    .pref_wdata (pref_wdata),
    .adapt_req  (adapt_req),
    .cur_code   (cur_code),
    .neg_state  (neg_state),
    .neg_done   (neg_done),
    .byte_mask  (byte_mask),
    .adapt_en   (adapt_en)
);

// File: tb/tb_hdlc_rate_arbiter.sv
`timescale 1ns/1ps
module tb_hdlc_rate_arbiter;

    localparam logic [4:0] CAPS = 5'b11011; // code 3 not supported locally

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_up = 1'b0;
    logic       pref_wr = 1'b0;
    logic [2:0] pref_wdata = 3'd0;
    logic       remote_valid = 1'b0;
    logic [4:0] remote_caps = 5'd0;
    logic [9:0] user_mask = 10'd0;
    logic       adapt_req = 1'b0;
    logic [2:0] cur_code;
    logic [1:0] neg_state;
    logic       neg_done;
    logic [9:0] byte_mask;
    logic       adapt_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit compare_on = 1'b0;

    // Reference model state
    int m_st = 0, m_code = 0, m_done = 0, m_bm = 0, m_pref = 5, m_rm = 0;

    always #2.5 clk = ~clk; // 200 MHz

    hdlc_rate_arbiter #(.DEFAULT_PREF(3'd5), .LOCAL_CAPS(CAPS), .MASK_W(10)) dut (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .pref_wr(pref_wr),
        .pref_wdata(pref_wdata), .remote_valid(remote_valid),
        .remote_caps(remote_caps), .user_mask(user_mask), .adapt_req(adapt_req),
        .cur_code(cur_code), .neg_state(neg_state), .neg_done(neg_done),
        .byte_mask(byte_mask), .adapt_en(adapt_en)
    );

    function automatic int best_common(int pref, int rmask);
        int b = 0;
        if (pref < 1 || pref > 5) return 0;
        for (int c = 1; c <= pref; c++)
            if (CAPS[c-1] && rmask[c-1]) b = c;
        return b;
    endfunction

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        bit acc, chg;
        int nd, b;
        cycles++;
        if (!rst_n) begin
            m_st = 0; m_code = 0; m_done = 0; m_bm = 0; m_pref = 5; m_rm = 0;
        end else begin
            acc = pref_wr && ((pref_wdata >= 1 && pref_wdata <= 5) || pref_wdata == 7);
            chg = acc && (int'(pref_wdata) != m_pref);
            nd = 0;
            if (!link_up) begin
                m_st = 0; m_code = 0; m_bm = 0;
            end else if (m_st != 0 && chg) begin
                m_st = 1; m_code = 0; m_bm = 0;
            end else if (m_st == 0) begin
                m_st = 1;
            end else if (m_st == 1) begin
                if (m_pref == 7) begin
                    m_st = 3; m_code = 7; nd = 1; m_bm = int'(user_mask);
                end else if (remote_valid) begin
                    m_rm = int'(remote_caps); m_st = 2;
                end
            end else if (m_st == 2) begin
                b = best_common(m_pref, m_rm);
                if (b != 0) begin m_st = 3; m_code = b; nd = 1; end
                else begin m_st = 1; m_code = 0; end
            end
            if (acc) m_pref = int'(pref_wdata);
            m_done = nd;
        end
        compare_on = 1'b1;
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the reference on every falling edge.
    always @(negedge clk) begin
        if (compare_on) begin
            chk("R2 state", int'(neg_state), m_st);
            chk("R4 cur_code", int'(cur_code), m_code);
            chk("R4 neg_done", int'(neg_done), m_done);
            chk("R8 byte_mask", int'(byte_mask), m_bm);
            chk("R9 adapt_en", int'(adapt_en),
                (adapt_req && m_st == 3 && m_code >= 1 && m_code <= 5) ? 1 : 0);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_pref(int v);
        pref_wr = 1'b1; pref_wdata = 3'(v);
        step(1);
        pref_wr = 1'b0;
    endtask

    // Watchdog
    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        chk("R1 reset state", int'(neg_state), 0);
        chk("R1 reset code", int'(cur_code), 0);
        chk("R1 reset done", int'(neg_done), 0);
        chk("R1 reset mask", int'(byte_mask), 0);

        rst_n = 1'b1; link_up = 1'b1; remote_caps = 5'b11111; remote_valid = 1'b1;
        step(1);
        chk("R2 idle to advertise", int'(neg_state), 1);
        chk("R10 code zero in advertise", int'(cur_code), 0);
        step(1);
        chk("R3 advertise to compare", int'(neg_state), 2);
        step(1);
        chk("R4 highest common code", int'(cur_code), 5);
        chk("R4 done pulse", int'(neg_done), 1);
        step(1);
        chk("R4 done one cycle", int'(neg_done), 0);

        wr_pref(3);
        chk("R7 restart on change", int'(neg_state), 1);
        chk("R7 code cleared", int'(cur_code), 0);
        step(2);
        chk("R3 offer capped by pref and caps", int'(cur_code), 2);

        wr_pref(3);
        chk("R7 same value no restart", int'(neg_state), 3);
        wr_pref(6);
        chk("R6 code 6 ignored", int'(neg_state), 3);
        wr_pref(0);
        chk("R6 code 0 ignored", int'(cur_code), 2);

        link_up = 1'b0;
        step(1);
        chk("R2 link drop to idle", int'(neg_state), 0);
        chk("R2 link drop code", int'(cur_code), 0);
        link_up = 1'b1;
        step(3);
        chk("R6 stored pref kept", int'(cur_code), 2);

        remote_caps = 5'b01100;
        wr_pref(5);
        step(2);
        chk("R3 remote mask limits pick", int'(cur_code), 4);

        remote_caps = 5'b11100;
        wr_pref(1);
        step(1);
        chk("R3 compare after restart", int'(neg_state), 2);
        step(1);
        chk("R5 no common back to advertise", int'(neg_state), 1);
        chk("R5 no common code zero", int'(cur_code), 0);
        chk("R5 no done", int'(neg_done), 0);
        remote_valid = 1'b0;
        step(3);
        chk("R5 waits in advertise", int'(neg_state), 1);

        user_mask = 10'b0000010101; adapt_req = 1'b1;
        wr_pref(7);
        chk("R8 still advertise after write", int'(neg_state), 1);
        step(1);
        chk("R8 user code", int'(cur_code), 7);
        chk("R8 user mask latched", int'(byte_mask), 10'b0000010101);
        chk("R8 user done", int'(neg_done), 1);
        chk("R9 adapt off in user mode", int'(adapt_en), 0);
        user_mask = 10'b1111100000;
        step(2);
        chk("R8 mask not retaken", int'(byte_mask), 10'b0000010101);

        remote_caps = 5'b00011; remote_valid = 1'b1;
        wr_pref(2);
        chk("R7 leaving user mode clears mask", int'(byte_mask), 0);
        step(2);
        chk("R4 code after user exit", int'(cur_code), 2);
        chk("R9 adapt follows request", int'(adapt_en), 1);
        adapt_req = 1'b0;
        step(1);
        chk("R9 adapt drops with request", int'(adapt_en), 0);

        step(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule